// File: doc/BRIEF.md
# Two's-Complement Adder-Subtractor with Signed Overflow

This block is a purely combinational two's-complement adder and subtractor. Its width is set by a parameter. A single control pin picks the operation: low adds the two operands, high subtracts the second operand from the first. The second operand passes through a conditioning stage. For subtraction that stage inverts the operand bit by bit and sets the initial carry to one. The result then comes from a chain of one-bit full adders, with the carry rippling from the least significant bit up to the sign bit.

The block presents three outputs: the wrapped result, the carry leaving the top stage, and a signed overflow flag. The flag compares the carry entering the sign position with the carry leaving it. It is raised when the true signed answer does not fit the width, whether the error is positive overflow or negative wraparound. The block holds no state, and its outputs follow its inputs after the ripple delay. It is meant to sit inside a larger datapath, which registers around it as needed. It has no streaming interface, because it holds and transfers no data between cycles.

Top module: `addsub_core`

## Requirements
- R1: With `sub_mode` = 0, `result` equals (`op_a` + `op_b`) modulo 2^WIDTH.
- R2: With `sub_mode` = 1, `result` equals (`op_a` − `op_b`) modulo 2^WIDTH, computed as `op_a` + bitwise-inverse(`op_b`) + 1.
- R3: With `sub_mode` = 0, `carry_out` equals bit WIDTH of the unsigned sum `op_a` + `op_b`.
- R4: With `sub_mode` = 1, `carry_out` equals bit WIDTH of `op_a` + inverse(`op_b`) + 1, which is 1 exactly when `op_a` ≥ `op_b` read as unsigned. Subtracting zero therefore gives `carry_out` = 1 and `result` = `op_a`.
- R5: `overflow` is 1 exactly when the signed value of the operation, with both operands read as two's complement, lies outside −2^(WIDTH−1) … 2^(WIDTH−1)−1.
- R6: An addition of operands whose sign bits differ never raises `overflow`. For example, with WIDTH = 4, 0111 + 1000 gives 1111 with `overflow` = 0.
- R7: With WIDTH = 4, 0111 + 0111 gives `result` 1110 with `overflow` = 1, and 1001 + 1001 gives `result` 0010 with `overflow` = 1.
- R8: Subtracting the most negative value (1 followed by zeros) raises `overflow` exactly when `op_a` is non-negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand (minuend when subtracting) |
| op_b | input | WIDTH | Second operand (subtrahend when subtracting) |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| result | output | WIDTH | Wrapped sum or difference |
| carry_out | output | 1 | Carry leaving the most significant stage |
| overflow | output | 1 | Signed overflow or negative wraparound |

## Verification
The hardest case to reach is a carry that starts at bit 0 and ripples across the full width into the sign stage. Random operands rarely produce it at eight bits. It appears when subtracting zero, or when adding an all-ones operand to one. A four-bit instance is therefore swept exhaustively over every operand pair in both modes, which covers every carry pattern at that width. The eight-bit instance takes seeded random vectors together with directed operands: zero, all ones, the most negative value and the most positive value, in both modes.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } addsub_op_e;
endpackage

// File: rtl/addsub_fa.sv
module addsub_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = x ^ y ^ ci;
    co = (x & y) | (ci & (x ^ y));
  end
endmodule

// File: rtl/addsub_operand.sv
module addsub_operand
  import addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] b_in,
  input  addsub_op_e       op,
  output logic [WIDTH-1:0] b_eff,
  output logic             carry_seed
);
  always_comb begin
    b_eff      = (op == OP_SUB) ? ~b_in : b_in;
    carry_seed = (op == OP_SUB);
  end
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             c_first,
  output logic [WIDTH-1:0] s,
  output logic             c_into_msb,
  output logic             c_out_msb
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] c;

  assign c[0] = c_first;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    addsub_fa u_fa (
      .x  (x[i]),
      .y  (y[i]),
      .ci (c[i]),
      .s  (s[i]),
      .co (c[i+1])
    );
  end

  assign c_into_msb = c[MSB];
  assign c_out_msb  = c[WIDTH];

  // R3 / R4: a generate at the top stage must show up as the chain's carry out
  always_comb begin
    if (!$isunknown({x[MSB], y[MSB]}))
      a_r3_top_generate: assert (!(x[MSB] && y[MSB]) || c_out_msb)
        else $error("top stage generate lost");
  end
endmodule

// File: rtl/addsub_core.sv
module addsub_core
  import addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow
);
  localparam int MSB = WIDTH - 1;

  addsub_op_e       op;
  logic [WIDTH-1:0] b_cond;
  logic             seed;
  logic             c_in_sign;
  logic             c_out_sign;

  assign op = addsub_op_e'(sub_mode);

  addsub_operand #(.WIDTH(WIDTH)) u_operand (
    .b_in       (op_b),
    .op         (op),
    .b_eff      (b_cond),
    .carry_seed (seed)
  );

  addsub_ripple #(.WIDTH(WIDTH)) u_chain (
    .x          (op_a),
    .y          (b_cond),
    .c_first    (seed),
    .s          (result),
    .c_into_msb (c_in_sign),
    .c_out_msb  (c_out_sign)
  );

  assign carry_out = c_out_sign;
  assign overflow  = c_in_sign ^ c_out_sign;

  always_comb begin
    if (!$isunknown({op_a, op_b, sub_mode})) begin
      // R6: opposite signs in add mode never overflow
      a_r6_no_overflow: assert (sub_mode || (op_a[MSB] == op_b[MSB]) || !overflow)
        else $error("overflow on mixed-sign addition");
      // R5: same effective signs with a flipped result sign must flag overflow
      a_r5_sign_flip: assert (!((op_a[MSB] == (op_b[MSB] ^ sub_mode)) &&
                                (result[MSB] != op_a[MSB]) && !(sub_mode && op_b == '0))
                              || overflow)
        else $error("sign flip not flagged");
      // R4: subtracting zero returns the minuend with carry set
      a_r4_sub_zero: assert (!(sub_mode && op_b == '0) || (carry_out && result == op_a && !overflow))
        else $error("subtract zero wrong");
    end
  end
endmodule

// File: tb/tb_addsub_core.sv
module tb_addsub_core;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] a8, b8;
  logic       m8;
  logic [7:0] r8;
  logic       c8, v8;
  logic [3:0] a4, b4;
  logic       m4;
  logic [3:0] r4;
  logic       c4, v4;

  addsub_core dut (
    .op_a(a8), .op_b(b8), .sub_mode(m8),
    .result(r8), .carry_out(c8), .overflow(v8)
  );

  addsub_core #(.WIDTH(4)) dut_n4 (
    .op_a(a4), .op_b(b4), .sub_mode(m4),
    .result(r4), .carry_out(c4), .overflow(v4)
  );

  function automatic int to_signed(int u, int w);
    return (u >= (1 << (w-1))) ? u - (1 << w) : u;
  endfunction

  // returns {overflow, carry, result}
  function automatic int model(int ua, int ub, bit m, int w);
    int mask = (1 << w) - 1;
    int raw  = m ? ua + ((~ub) & mask) + 1 : ua + ub;
    int sv   = m ? to_signed(ua, w) - to_signed(ub, w) : to_signed(ua, w) + to_signed(ub, w);
    bit ov   = (sv < -(1 << (w-1))) || (sv > (1 << (w-1)) - 1);
    return (int'(ov) << (w+1)) | (((raw >> w) & 1) << w) | (raw & mask);
  endfunction

  task automatic cmp(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run8(int ua, int ub, bit m, string req);
    int e;
    @(negedge clk);
    a8 = ua[7:0]; b8 = ub[7:0]; m8 = m;
    #2;
    e = model(ua, ub, m, 8);
    cmp({req, " result"}, int'(r8), e & 8'hFF);
    cmp(m ? "R4 carry" : "R3 carry", int'(c8), (e >> 8) & 1);
    cmp("R5 overflow", int'(v8), (e >> 9) & 1);
  endtask

  task automatic run4(int ua, int ub, bit m, string req);
    int e;
    @(negedge clk);
    a4 = ua[3:0]; b4 = ub[3:0]; m4 = m;
    #2;
    e = model(ua, ub, m, 4);
    cmp({req, " result"}, int'(r4), e & 4'hF);
    cmp(m ? "R4 carry" : "R3 carry", int'(c4), (e >> 4) & 1);
    cmp("R5 overflow", int'(v4), (e >> 5) & 1);
  endtask

  initial begin
    a8 = '0; b8 = '0; m8 = 1'b0;
    a4 = '0; b4 = '0; m4 = 1'b0;
    #3;
    cmp("R1 zero state", int'({v8, c8, r8}), 0);

    // R7 directed corners at four bits
    @(negedge clk); a4 = 4'h7; b4 = 4'h7; m4 = 1'b0; #2;
    cmp("R7 7+7 result", int'(r4), 4'hE);
    cmp("R7 7+7 overflow", int'(v4), 1);
    @(negedge clk); a4 = 4'h9; b4 = 4'h9; m4 = 1'b0; #2;
    cmp("R7 -7+-7 result", int'(r4), 4'h2);
    cmp("R7 -7+-7 overflow", int'(v4), 1);
    // R6 mixed signs
    @(negedge clk); a4 = 4'h7; b4 = 4'h8; m4 = 1'b0; #2;
    cmp("R6 7+-8 result", int'(r4), 4'hF);
    cmp("R6 7+-8 overflow", int'(v4), 0);
    // R8 subtract most negative
    @(negedge clk); a4 = 4'h0; b4 = 4'h8; m4 = 1'b1; #2;
    cmp("R8 0-(-8) overflow", int'(v4), 1);
    @(negedge clk); a4 = 4'hF; b4 = 4'h8; m4 = 1'b1; #2;
    cmp("R8 -1-(-8) overflow", int'(v4), 0);
    // R4 subtract zero: full-length ripple
    @(negedge clk); a8 = 8'hA5; b8 = 8'h00; m8 = 1'b1; #2;
    cmp("R4 sub zero carry", int'(c8), 1);
    cmp("R4 sub zero result", int'(r8), 8'hA5);

    // exhaustive four-bit sweep (R1, R2)
    for (int m = 0; m < 2; m++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          run4(x, y, bit'(m), m ? "R2" : "R1");

    // directed eight-bit corners
    run8(8'hFF, 8'h01, 1'b0, "R1");
    run8(8'h7F, 8'h01, 1'b0, "R1");
    run8(8'h80, 8'hFF, 1'b0, "R1");
    run8(8'h80, 8'h01, 1'b1, "R2");
    run8(8'h7F, 8'h80, 1'b1, "R8");
    run8(8'h80, 8'h80, 1'b1, "R8");
    run8(8'h00, 8'h00, 1'b1, "R2");

    // seeded random eight-bit vectors
    void'($urandom(32'd20240611));
    for (int k = 0; k < 3000; k++)
      run8(int'($urandom & 32'hFF), int'($urandom & 32'hFF), bit'($urandom & 1), "R1/R2 random");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule